// File: doc/BRIEF.md
# SPI master shift engine

This block is a single-clock SPI master. Each transaction sends one word and receives one word, either 8 or 16 bits long. A word to send is offered on a valid/ready input. The word that comes back is offered on a valid/ready output. SCK is not a derived clock. It is a register that toggles on enable strobes from a power-of-two divider, so the whole block runs in the system clock domain.

At the moment a word is accepted, the block captures its configuration: clock polarity, clock phase, bit order, word size and divisor. It then drops chip select. It waits one half SCK period, runs all the SCK edges, waits another half period and releases chip select. MOSI is held in a register that changes only on shifting edges, so it is steady around every sampling edge.

A received word must be taken before the next word can be accepted. A user that only sends data ties `rx_ready` high.

Top module: `spim_core`

## Requirements
- R1: Once a transfer has started, consecutive SCK edges are exactly 2^div system clock cycles apart. `div` is the 3-bit divisor field, so the SCK period is 2^(div+1) cycles.
- R2: While idle, SCK rests at the polarity input. A transfer of N bits makes exactly 2N SCK edges, and SCK is back at the captured polarity when chip select rises.
- R3: With phase 0, MISO is sampled on the odd edges (1st, 3rd, ...) and MOSI changes on the even edges. The first bit is on MOSI from the cycle in which CS_N falls. With phase 1, MOSI changes on the odd edges and MISO is sampled on the even edges.
- R4: During a transfer, MOSI changes only in a cycle in which SCK also changes.
- R5: With `cfg_lsb_first`=1, bit 0 is sent and received first. Otherwise the highest bit of the word goes first.
- R6: With `cfg_wide`=0 the word is 8 bits: `tx_data[15:8]` is ignored and `rx_data[15:8]` reads zero. With `cfg_wide`=1 the word is 16 bits.
- R7: CS_N falls in the cycle after acceptance. The first SCK edge comes 2^div cycles after that. CS_N rises 2^div cycles after the last edge.
- R8: `busy` is high exactly while CS_N is low. `tx_ready` is low while busy or while `rx_valid` is high. After reset, `tx_ready`=1, `busy`=0 and CS_N=1.
- R9: `rx_valid` rises in the same cycle that CS_N rises. It then holds, together with a stable `rx_data`, until a cycle in which `rx_ready` is high.
- R10: Configuration inputs are captured only at acceptance. Changing them during a transfer has no effect on that transfer.
- R11: `sck_oe` and `csn_oe` are high from the first clock after reset. `mosi_oe` is high only while CS_N is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on first edge of a bit, 1: shift on first edge |
| cfg_lsb_first | input | 1 | bit order select |
| cfg_wide | input | 1 | 0: 8-bit word, 1: 16-bit word |
| cfg_div | input | DIV_W | half-period is 2^cfg_div clocks |
| tx_valid | input | 1 | word offered for sending |
| tx_ready | output | 1 | word can be accepted |
| tx_data | input | 16 | word to send |
| rx_valid | output | 1 | received word available |
| rx_ready | input | 1 | received word taken |
| rx_data | output | 16 | received word |
| busy | output | 1 | transfer in progress |
| sck_o | output | 1 | SCK value |
| sck_oe | output | 1 | SCK drive enable |
| mosi_o | output | 1 | MOSI value |
| mosi_oe | output | 1 | MOSI drive enable |
| csn_o | output | 1 | chip select value, active low |
| csn_oe | output | 1 | chip select drive enable |
| miso_i | input | 1 | MISO pin |

## Verification
The bench sweeps every combination of polarity, phase, bit order and word size at divisors 0, 1 and 2, and adds one transfer at divisor 7. A slave model in the bench measures every edge spacing and exchanges bits against the pins. Arbitrary mixed words catch datapath errors. One-hot words (bit 0 against bit 15) tell a bit-order swap apart from a lost or misplaced bit. Delayed `rx_ready` shows that the received word is held. Configuration inputs are inverted during some transfers, which shows that the captured settings and not the live inputs steer the transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // position in the word of the j-th bit on the wire
    function automatic int bit_slot(logic lsb_first, int nbits, int j);
        return lsb_first ? j : (nbits - 1 - j);
    endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int unsigned CW = (1 << DIV_W) - 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim   = (CW'(1) << div) - CW'(1);
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spim_rxcol.sv
module spim_rxcol #(
    parameter int unsigned W  = 16,
    parameter int unsigned NW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sample,
    input  logic         bit_i,
    input  logic         lsb_first,
    input  logic         wide,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clr) begin
            word_d = '0;
        end else if (sample) begin
            if (lsb_first) begin
                word_d = word_q >> 1;
                if (wide) word_d[W-1]  = bit_i;
                else      word_d[NW-1] = bit_i;
            end else begin
                word_d = {word_q[W-2:0], bit_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;

endmodule

// File: rtl/spim_core.sv
module spim_core #(
    parameter int unsigned DIV_W    = 3,
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_wide,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [WIDE_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [WIDE_W-1:0] rx_data,
    output logic              busy,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    output logic              csn_o,
    output logic              csn_oe,
    input  logic              miso_i
);
    import spim_pkg::*;

    localparam int unsigned W     = WIDE_W;
    localparam int unsigned CNT_W = $clog2(2 * W + 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic             sck;
        logic             mosi;
        logic             oe;
        logic             rxv;
        logic [W-1:0]     rxd;
        logic [W-1:0]     txw;
        logic             cpol;
        logic             cpha;
        logic             lsb;
        logic             wide;
        logic [DIV_W-1:0] div;
    } st_t;

    st_t          st_d, st_q;
    logic         tick;
    logic         smp;
    logic         clr;
    logic [W-1:0] rx_word;
    logic [CNT_W-1:0] edges;

    spim_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.act),
        .div  (st_q.div),
        .tick (tick)
    );

    spim_rxcol #(.W(W), .NW(NARROW_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .sample   (smp),
        .bit_i    (miso_i),
        .lsb_first(st_q.lsb),
        .wide     (st_q.wide),
        .word_o   (rx_word)
    );

    assign tx_ready = !st_q.act && !st_q.rxv;
    assign edges    = st_q.wide ? CNT_W'(2 * WIDE_W) : CNT_W'(2 * NARROW_W);

    always_comb begin
        logic [CNT_W-1:0] e;
        logic [CNT_W-1:0] j;
        int               nb;
        logic [W-1:0]     sh;

        st_d    = st_q;
        st_d.oe = 1'b1;
        smp     = 1'b0;
        clr     = 1'b0;
        e       = st_q.cnt + 1'b1;
        j       = e >> 1;
        nb      = st_q.wide ? int'(WIDE_W) : int'(NARROW_W);
        sh      = '0;

        if (!st_q.act) begin
            st_d.sck = cfg_cpol;
            if (st_q.rxv && rx_ready) st_d.rxv = 1'b0;
            if (tx_valid && tx_ready) begin
                st_d.act  = 1'b1;
                st_d.cnt  = '0;
                st_d.txw  = tx_data;
                st_d.cpol = cfg_cpol;
                st_d.cpha = cfg_cpha;
                st_d.lsb  = cfg_lsb_first;
                st_d.wide = cfg_wide;
                st_d.div  = cfg_div;
                clr       = 1'b1;
                sh = tx_data >> bit_slot(cfg_lsb_first,
                                         cfg_wide ? int'(WIDE_W) : int'(NARROW_W), 0);
                st_d.mosi = cfg_cpha ? 1'b0 : sh[0];
            end
        end else if (tick) begin
            if (st_q.cnt == edges) begin
                st_d.act = 1'b0;
                st_d.rxv = 1'b1;
                st_d.rxd = st_q.wide ? rx_word
                                     : {{(W-NARROW_W){1'b0}}, rx_word[NARROW_W-1:0]};
            end else begin
                st_d.sck = !st_q.sck;
                st_d.cnt = e;
                if (e[0] ^ st_q.cpha) begin
                    smp = 1'b1;
                end else if (int'(j) < nb) begin
                    sh        = st_q.txw >> bit_slot(st_q.lsb, nb, int'(j));
                    st_d.mosi = sh[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck_o   = st_q.sck;
    assign sck_oe  = st_q.oe;
    assign csn_o   = !st_q.act;
    assign csn_oe  = st_q.oe;
    assign mosi_o  = st_q.mosi;
    assign mosi_oe = st_q.act;
    assign busy    = st_q.act;
    assign rx_valid = st_q.rxv;
    assign rx_data = st_q.rxd;

    // SCK ends each transfer at the captured idle level
    a_r2_sck_rests: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.act) |-> st_q.sck == st_q.cpol);

    // edge counter never runs past the word's edge total
    a_r2_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= edges);

    // SCK moves only after a divider strobe
    a_r1_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act && $past(st_q.act) && !$stable(st_q.sck) |-> $past(tick));

    // MOSI moves only together with an SCK edge
    a_r4_mosi_with_edge: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act && $past(st_q.act) && !$stable(st_q.mosi) |-> !$stable(st_q.sck));

    // received word held until taken
    a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rxv && !rx_ready |=> st_q.rxv && $stable(st_q.rxd));

    // captured configuration frozen during a transfer
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act && $past(st_q.act) |-> $stable(st_q.cpol) && $stable(st_q.cpha)
            && $stable(st_q.lsb) && $stable(st_q.wide) && $stable(st_q.div));

endmodule

// File: tb/spim_core_tb_top.sv
module spim_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_wide = 1'b0;
    logic [2:0]  cfg_div = 3'd0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] tx_data = 16'h0;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic [15:0] rx_data;
    logic        busy, sck_o, sck_oe, mosi_o, mosi_oe, csn_o, csn_oe;
    logic        miso_r = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spim_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_wide(cfg_wide), .cfg_div(cfg_div),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .busy(busy), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
        .mosi_oe(mosi_oe), .csn_o(csn_o), .csn_oe(csn_oe), .miso_i(miso_r)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // slave-side view of the current transfer
    logic        s_cpol, s_cpha, s_lsb;
    int          s_h, s_n;
    logic [15:0] s_word, e_tx, s_got;
    int          cyc = 0, t_cs = 0, t_last = 0, ecnt = 0, done_cnt = 0;
    logic        p_sck = 1'b0, p_csn = 1'b1, p_mosi = 1'b0;

    function automatic int slot(int j);
        return s_lsb ? j : (s_n - 1 - j);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_csn && !csn_o) begin
                t_cs = cyc; ecnt = 0; s_got = '0;
                chk(busy == 1'b1, "R8 busy at select", busy, 1);
                chk(tx_ready == 1'b0, "R8 ready low", tx_ready, 0);
                chk(mosi_oe == 1'b1, "R11 mosi_oe", mosi_oe, 1);
                chk(sck_o == s_cpol, "R2 idle level", sck_o, s_cpol);
                if (!s_cpha) begin
                    chk(mosi_o == e_tx[slot(0)], "R3 first bit early", mosi_o, e_tx[slot(0)]);
                    miso_r = s_word[slot(0)];
                end
            end else if (!csn_o && !p_csn && sck_o != p_sck) begin
                ecnt++;
                if (ecnt == 1) chk(cyc - t_cs == s_h, "R7 lead", cyc - t_cs, s_h);
                else           chk(cyc - t_last == s_h, "R1 spacing", cyc - t_last, s_h);
                t_last = cyc;
                if (((ecnt % 2) == 1) == (s_cpha == 1'b0)) begin
                    s_got[slot((ecnt - 1) / 2)] = mosi_o;
                    chk(mosi_o == e_tx[slot((ecnt - 1) / 2)], "R5 mosi bit",
                        mosi_o, e_tx[slot((ecnt - 1) / 2)]);
                end else if (ecnt / 2 < s_n) begin
                    miso_r = s_word[slot(ecnt / 2)];
                end
            end else if (!p_csn && csn_o) begin
                chk(cyc - t_last == s_h, "R7 trail", cyc - t_last, s_h);
                chk(ecnt == 2 * s_n, "R2 edge total", ecnt, 2 * s_n);
                chk(sck_o == s_cpol, "R2 rest level", sck_o, s_cpol);
                chk(rx_valid == 1'b1, "R9 valid at release", rx_valid, 1);
                chk(busy == 1'b0, "R8 busy off", busy, 0);
                chk(mosi_oe == 1'b0, "R11 mosi_oe off", mosi_oe, 0);
                done_cnt++;
            end
            if (!csn_o && !p_csn && mosi_o != p_mosi && sck_o == p_sck)
                chk(1'b0, "R4 mosi moved without edge", mosi_o, p_mosi);
            p_sck = sck_o; p_csn = csn_o; p_mosi = mosi_o;
        end
    end

    task automatic xfer(input logic cp, input logic ph, input logic lsb, input logic wd,
                        input logic [2:0] dv, input logic [15:0] tw, input logic [15:0] sw,
                        input int rdly, input bit scr);
        logic [15:0] mask, got;
        int wait_n;
        s_cpol = cp; s_cpha = ph; s_lsb = lsb;
        s_h = 1 << dv; s_n = wd ? 16 : 8;
        s_word = sw; e_tx = tw;
        mask = wd ? 16'hFFFF : 16'h00FF;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R8 ready idle", tx_ready, 1);
        cfg_cpol = cp; cfg_cpha = ph; cfg_lsb_first = lsb; cfg_wide = wd; cfg_div = dv;
        tx_data = tw; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        if (scr) begin
            // R10: scramble live configuration while the transfer runs
            cfg_cpol = ~cp; cfg_cpha = ~ph; cfg_lsb_first = ~lsb; cfg_wide = ~wd;
            cfg_div = dv ^ 3'd1;
        end
        wait_n = 0;
        while (!rx_valid && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        chk((rx_data & mask) == (sw & mask), scr ? "R10 rx word" : "R3 rx word",
            rx_data, sw & mask);
        chk((rx_data & ~mask) == 16'h0, "R6 upper zero", rx_data, sw & mask);
        chk(s_got == (tw & mask), scr ? "R10 tx word" : "R5 tx word", s_got, tw & mask);
        got = rx_data;
        for (int k = 0; k < rdly; k++) begin
            @(negedge clk);
            chk(rx_valid && rx_data == got, "R9 hold", rx_data, got);
            chk(tx_ready == 1'b0, "R8 blocked by rx", tx_ready, 0);
        end
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk(rx_valid == 1'b0, "R9 taken", rx_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", done_cnt, 97);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        s_cpol = 0; s_cpha = 0; s_lsb = 0; s_h = 1; s_n = 8;
        s_word = 0; e_tx = 0; s_got = 0;
        repeat (3) @(negedge clk);
        chk(csn_o == 1'b1, "R8 reset csn", csn_o, 1);
        chk(busy == 1'b0, "R8 reset busy", busy, 0);
        chk(rx_valid == 1'b0, "R9 reset valid", rx_valid, 0);
        chk(tx_ready == 1'b1, "R8 reset ready", tx_ready, 1);
        chk(mosi_oe == 1'b0, "R11 reset mosi_oe", mosi_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sck_oe && csn_oe, "R11 oe after reset", {sck_oe, csn_oe}, 3);
        for (int d = 0; d < 3; d++)
            for (int c = 0; c < 16; c++) begin
                int k;
                k = d * 16 + c;
                xfer(c[0], c[1], c[2], c[3], 3'(d),
                     16'hA55A ^ 16'(k * 16'h1357), 16'h3C96 + 16'(k * 16'h0F0F),
                     k % 3, (k % 2) == 1);
                xfer(c[0], c[1], c[2], c[3], 3'(d),
                     c[3] ? 16'h0001 : 16'hFF01, c[3] ? 16'h8000 : 16'h0080, 0, 1'b0);
            end
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 16'h00C5, 16'h005A, 1, 1'b0);
        chk(done_cnt == 97, "R2 transfers completed", done_cnt, 97);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule